// File: doc/BRIEF.md
# Event Performance Monitor

This block counts hardware events for an accelerator so that software can profile it. It holds a parameterised number of event counters, four by default, each 32 bits wide. Every counter has its own selector that picks one line of an event input vector. A 64-bit cycle counter is armed by one chosen event and disarmed by another. Software reaches everything through a single-cycle word write port and a combinational read port. A level interrupt is raised when a counter wraps and its interrupt enable is set.

All mask-style registers use one bit layout. Bit i (for i from 0 to NUM_CNT-1) stands for event counter i, and bit 31 stands for the cycle counter. A CTRL write holds the global on/off switch and two self-clearing clear commands. Counter values can be preloaded, and a write to the software-increment register bumps any selected counter by one.

Top module: `perf_mon`

## Requirements
- R1: After reset, all event counts and both cycle-counter halves read zero. CTRL, the enable mask, the overflow status and the interrupt mask also read zero. CYC_CFG reads 0x0000_0001, and irq_o is low.
- R2: Writing a mask to EN_SET (address 1) sets the counter-enable bits that are 1 in it, and writing to EN_CLR (address 2) clears them. Reading either address returns the mask. The mask changes only on those writes.
- R3: Selector value 0 never counts. Value 1 counts every clock. A value k of 2 or more counts each clock at which events_i[k-2] is high, and a value beyond NUM_EVT_IN+1 never counts. Counting needs both CTRL bit 0 (global enable) and the counter's enable bit. Selectors live at address 10+i.
- R4: Writing address 10+NUM_CNT+i loads counter i. The loaded value is what the counter holds after that edge, even if an event was counted in the same clock.
- R5: In a write to CTRL (address 0), bit 0 sets the global enable, a 1 in bit 1 zeroes every event counter, and a 1 in bit 2 zeroes the cycle counter.
- R6: A write to SWINC (address 6) adds one to every counter whose mask bit is 1, whatever the enables are.
- R7: The cycle counter reads as a low word at address 8 and a high word at address 9, and each word can be loaded. The carry out of the low word reaches the high word at the same edge that wraps the low word.
- R8: CYC_CFG (address 7) holds a start event in bits [9:0] and a stop event in bits [25:16], both numbered as in R3. After a start event, counting begins at the next clock. It runs up to and including the clock at which the stop event is seen, and stop wins if both are seen together.
- R9: When a counter wraps, its bit is set in the overflow status (address 3). The bit stays set until a write to address 3 with a 1 in that bit position, and writing 0 leaves it alone.
- R10: IRQ_SET (address 4) and IRQ_CLR (address 5) set and clear the interrupt mask, and either address reads it back. irq_o is high while any overflow bit and its mask bit are both 1.
- R11: The cycle counter holds its value while it is unarmed, while bit 31 of the enable mask is clear, or while the global enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| events_i | input | NUM_EVT_IN | Event lines, synchronous to clk |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The checker assumes that events_i is synchronous to clk. It also assumes that every change to counter contents apart from event counting comes from a register write, so with wr_en_i low an ungated counter and the enable mask must not move. The bench changes events and write strobes only at falling edges, and it makes at most one write per clock. It starts and stops counting windows by writing the global enable, so the exact number of counted edges is known. Wrap cases are reached by preloading counters and using software increment while the global enable is off, so no background counting disturbs the expected values.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
   // Word addresses of the fixed registers
   localparam int ADR_CTRL    = 0;
   localparam int ADR_EN_SET  = 1;
   localparam int ADR_EN_CLR  = 2;
   localparam int ADR_OVF     = 3;
   localparam int ADR_IRQ_SET = 4;
   localparam int ADR_IRQ_CLR = 5;
   localparam int ADR_SWINC   = 6;
   localparam int ADR_CYC_CFG = 7;
   localparam int ADR_CYC_LO  = 8;
   localparam int ADR_CYC_HI  = 9;
   localparam int SEL_BASE    = 10;
   // Register data width and mask bit of the cycle counter
   localparam int DATA_W      = 32;
   localparam int CYC_BIT     = 31;
   // Bit position of the stop event field in CYC_CFG
   localparam int STOP_LSB    = 16;
   // CTRL bits
   localparam int CTRL_GLOB   = 0;
   localparam int CTRL_EVCLR  = 1;
   localparam int CTRL_CYCLR  = 2;
endpackage

// File: rtl/perf_mon_evt_sel.sv
module perf_mon_evt_sel #(
   parameter int NUM_EVT_IN = 32,
   parameter int EVT_W      = 10
) (
   input  logic [EVT_W-1:0]      sel_i,
   input  logic [NUM_EVT_IN-1:0] events_i,
   output logic                  hit_o
);
   localparam int EXT_W = NUM_EVT_IN + 2;

   if (EXT_W > (1 << EVT_W)) begin : g_bad_w
      $error("EVT_W too narrow for NUM_EVT_IN");
   end

   // code 0 never, code 1 always, code k>=2 is events_i[k-2]
   logic [EXT_W-1:0] ext;
   assign ext = {events_i, 1'b1, 1'b0};

   always_comb begin
      hit_o = 1'b0;
      for (int k = 0; k < EXT_W; k++) begin
         if (sel_i == EVT_W'(k)) hit_o = ext[k];
      end
   end
endmodule

// File: rtl/perf_mon_evt_cnt.sv
module perf_mon_evt_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             cnt_en_i,
   input  logic             sw_inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   sum;

   assign sum    = {1'b0, cnt_q} + (CNT_W+1)'(cnt_en_i) + (CNT_W+1)'(sw_inc_i);
   assign wrap_o = sum[CNT_W] && !clr_i && !load_i;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else             cnt_q <= sum[CNT_W-1:0];
   end
endmodule

// File: rtl/perf_mon_cyc_cnt.sv
module perf_mon_cyc_cnt #(
   parameter int HALF_W     = 32,
   parameter int NUM_EVT_IN = 32,
   parameter int EVT_W      = 10,
   parameter bit GATE_EN    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  ld_lo_i,
   input  logic                  ld_hi_i,
   input  logic [HALF_W-1:0]     ld_val_i,
   input  logic                  cnt_en_i,
   input  logic                  sw_inc_i,
   input  logic [EVT_W-1:0]      start_sel_i,
   input  logic [EVT_W-1:0]      stop_sel_i,
   input  logic [NUM_EVT_IN-1:0] events_i,
   output logic [2*HALF_W-1:0]   cyc_o,
   output logic                  run_o,
   output logic                  wrap_o
);
   logic [HALF_W-1:0] lo_q, hi_q;
   logic [HALF_W:0]   lo_sum, hi_sum;
   logic [1:0]        inc;
   logic              blocked;

   if (GATE_EN) begin : g_gated
      logic start_hit, stop_hit, run_q;
      perf_mon_evt_sel #(.NUM_EVT_IN(NUM_EVT_IN), .EVT_W(EVT_W)) start_sel_i_u (
         .sel_i(start_sel_i), .events_i(events_i), .hit_o(start_hit));
      perf_mon_evt_sel #(.NUM_EVT_IN(NUM_EVT_IN), .EVT_W(EVT_W)) stop_sel_i_u (
         .sel_i(stop_sel_i), .events_i(events_i), .hit_o(stop_hit));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         run_q <= 1'b0;
         else if (stop_hit)  run_q <= 1'b0;
         else if (start_hit) run_q <= 1'b1;
      end
      assign run_o = run_q;
   end else begin : g_free
      assign run_o = 1'b1;
   end

   assign blocked = clr_i || ld_lo_i || ld_hi_i;
   assign inc     = 2'(cnt_en_i && run_o) + 2'(sw_inc_i);
   assign lo_sum  = {1'b0, lo_q} + (HALF_W+1)'(inc);
   assign hi_sum  = {1'b0, hi_q} + (HALF_W+1)'(lo_sum[HALF_W]);
   assign wrap_o  = hi_sum[HALF_W] && !blocked;
   assign cyc_o   = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (clr_i) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (blocked) begin
         if (ld_lo_i) lo_q <= ld_val_i;
         if (ld_hi_i) hi_q <= ld_val_i;
      end else begin
         lo_q <= lo_sum[HALF_W-1:0];
         hi_q <= hi_sum[HALF_W-1:0];
      end
   end
endmodule

// File: rtl/perf_mon.sv
module perf_mon
   import perf_mon_pkg::*;
#(
   parameter int NUM_CNT     = 4,
   parameter int CNT_W       = 32,
   parameter int NUM_EVT_IN  = 32,
   parameter int EVT_W       = 10,
   parameter int ADDR_W      = 5,
   parameter bit CYC_GATE_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     wr_addr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   output logic [DATA_W-1:0]     rd_data_o,
   input  logic [NUM_EVT_IN-1:0] events_i,
   output logic                  irq_o
);
   localparam int CNT_BASE = SEL_BASE + NUM_CNT;
   localparam int HALF_W   = DATA_W;

   if (NUM_CNT < 1 || NUM_CNT > CYC_BIT) begin : g_bad_n
      $error("NUM_CNT out of range");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cw
      $error("CNT_W out of range");
   end
   if (EVT_W > STOP_LSB) begin : g_bad_ew
      $error("EVT_W too wide for CYC_CFG");
   end
   if (CNT_BASE + NUM_CNT > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too narrow");
   end

   // ---------------- register state
   logic               glob_en_q, cyc_en_q, cyc_irqen_q, cyc_ovf_q;
   logic [NUM_CNT-1:0] en_q, irqen_q, ovf_q;
   logic [EVT_W-1:0]   start_q, stop_q;
   logic [EVT_W-1:0]   sel_q [NUM_CNT];

   logic [CNT_W-1:0]    cnt_val [NUM_CNT];
   logic [NUM_CNT-1:0]  evt_wrap;
   logic [2*HALF_W-1:0] cyc_val;
   logic                cyc_run, cyc_wrap, cyc_open;
   logic [DATA_W-1:0]   en_mask, ovf_mask, irq_mask;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   logic wr_ctrl, wr_ovf, wr_sw, evt_clr, cyc_clr;
   assign wr_ctrl = wr_en_i && hit(wr_addr_i, ADR_CTRL);
   assign wr_ovf  = wr_en_i && hit(wr_addr_i, ADR_OVF);
   assign wr_sw   = wr_en_i && hit(wr_addr_i, ADR_SWINC);
   assign evt_clr = wr_ctrl && wr_data_i[CTRL_EVCLR];
   assign cyc_clr = wr_ctrl && wr_data_i[CTRL_CYCLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en_q   <= 1'b0;
         en_q        <= '0;
         cyc_en_q    <= 1'b0;
         irqen_q     <= '0;
         cyc_irqen_q <= 1'b0;
         start_q     <= EVT_W'(1);
         stop_q      <= '0;
         for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '0;
      end else if (wr_en_i) begin
         if (hit(wr_addr_i, ADR_CTRL)) glob_en_q <= wr_data_i[CTRL_GLOB];
         if (hit(wr_addr_i, ADR_EN_SET)) begin
            en_q     <= en_q | wr_data_i[NUM_CNT-1:0];
            cyc_en_q <= cyc_en_q | wr_data_i[CYC_BIT];
         end
         if (hit(wr_addr_i, ADR_EN_CLR)) begin
            en_q     <= en_q & ~wr_data_i[NUM_CNT-1:0];
            cyc_en_q <= cyc_en_q & ~wr_data_i[CYC_BIT];
         end
         if (hit(wr_addr_i, ADR_IRQ_SET)) begin
            irqen_q     <= irqen_q | wr_data_i[NUM_CNT-1:0];
            cyc_irqen_q <= cyc_irqen_q | wr_data_i[CYC_BIT];
         end
         if (hit(wr_addr_i, ADR_IRQ_CLR)) begin
            irqen_q     <= irqen_q & ~wr_data_i[NUM_CNT-1:0];
            cyc_irqen_q <= cyc_irqen_q & ~wr_data_i[CYC_BIT];
         end
         if (hit(wr_addr_i, ADR_CYC_CFG)) begin
            start_q <= wr_data_i[EVT_W-1:0];
            stop_q  <= wr_data_i[STOP_LSB +: EVT_W];
         end
         for (int i = 0; i < NUM_CNT; i++) begin
            if (hit(wr_addr_i, SEL_BASE + i)) sel_q[i] <= wr_data_i[EVT_W-1:0];
         end
      end
   end

   // Overflow status: set by a wrap, cleared by a 1 written to its bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q     <= '0;
         cyc_ovf_q <= 1'b0;
      end else begin
         ovf_q     <= (ovf_q & ~({NUM_CNT{wr_ovf}} & wr_data_i[NUM_CNT-1:0])) | evt_wrap;
         cyc_ovf_q <= (cyc_ovf_q & ~(wr_ovf & wr_data_i[CYC_BIT])) | cyc_wrap;
      end
   end

   // ---------------- counters
   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      logic ev_hit;
      perf_mon_evt_sel #(.NUM_EVT_IN(NUM_EVT_IN), .EVT_W(EVT_W)) sel_u (
         .sel_i(sel_q[g]), .events_i(events_i), .hit_o(ev_hit));
      perf_mon_evt_cnt #(.CNT_W(CNT_W)) cnt_u (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_i      (evt_clr),
         .load_i     (wr_en_i && hit(wr_addr_i, CNT_BASE + g)),
         .load_val_i (wr_data_i[CNT_W-1:0]),
         .cnt_en_i   (glob_en_q && en_q[g] && ev_hit),
         .sw_inc_i   (wr_sw && wr_data_i[g]),
         .cnt_o      (cnt_val[g]),
         .wrap_o     (evt_wrap[g]));
   end

   perf_mon_cyc_cnt #(
      .HALF_W(HALF_W), .NUM_EVT_IN(NUM_EVT_IN), .EVT_W(EVT_W), .GATE_EN(CYC_GATE_EN)
   ) cyc_u (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (cyc_clr),
      .ld_lo_i     (wr_en_i && hit(wr_addr_i, ADR_CYC_LO)),
      .ld_hi_i     (wr_en_i && hit(wr_addr_i, ADR_CYC_HI)),
      .ld_val_i    (wr_data_i),
      .cnt_en_i    (glob_en_q && cyc_en_q),
      .sw_inc_i    (wr_sw && wr_data_i[CYC_BIT]),
      .start_sel_i (start_q),
      .stop_sel_i  (stop_q),
      .events_i    (events_i),
      .cyc_o       (cyc_val),
      .run_o       (cyc_run),
      .wrap_o      (cyc_wrap));

   assign cyc_open = glob_en_q && cyc_en_q && cyc_run;

   // ---------------- mask views, interrupt, read port
   always_comb begin
      en_mask  = '0;
      ovf_mask = '0;
      irq_mask = '0;
      en_mask[NUM_CNT-1:0]  = en_q;
      ovf_mask[NUM_CNT-1:0] = ovf_q;
      irq_mask[NUM_CNT-1:0] = irqen_q;
      en_mask[CYC_BIT]  = cyc_en_q;
      ovf_mask[CYC_BIT] = cyc_ovf_q;
      irq_mask[CYC_BIT] = cyc_irqen_q;
   end

   assign irq_o = |(ovf_mask & irq_mask);

   always_comb begin
      rd_data_o = '0;
      if (hit(rd_addr_i, ADR_CTRL))    rd_data_o[CTRL_GLOB] = glob_en_q;
      if (hit(rd_addr_i, ADR_EN_SET) || hit(rd_addr_i, ADR_EN_CLR))   rd_data_o = en_mask;
      if (hit(rd_addr_i, ADR_OVF))     rd_data_o = ovf_mask;
      if (hit(rd_addr_i, ADR_IRQ_SET) || hit(rd_addr_i, ADR_IRQ_CLR)) rd_data_o = irq_mask;
      if (hit(rd_addr_i, ADR_CYC_CFG)) begin
         rd_data_o[EVT_W-1:0]          = start_q;
         rd_data_o[STOP_LSB +: EVT_W]  = stop_q;
      end
      if (hit(rd_addr_i, ADR_CYC_LO))  rd_data_o = cyc_val[HALF_W-1:0];
      if (hit(rd_addr_i, ADR_CYC_HI))  rd_data_o = cyc_val[2*HALF_W-1:HALF_W];
      for (int i = 0; i < NUM_CNT; i++) begin
         if (hit(rd_addr_i, SEL_BASE + i)) rd_data_o = DATA_W'(sel_q[i]);
         if (hit(rd_addr_i, CNT_BASE + i)) rd_data_o = DATA_W'(cnt_val[i]);
      end
   end
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk
   import perf_mon_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int CNT_W  = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en_i,
   input logic [ADDR_W-1:0]   wr_addr_i,
   input logic                irq_o,
   input logic                glob_en_q,
   input logic [DATA_W-1:0]   en_mask,
   input logic [DATA_W-1:0]   ovf_mask,
   input logic [2*DATA_W-1:0] cyc_val,
   input logic                cyc_open,
   input logic [CNT_W-1:0]    cnt0
);
   // R2
   en_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(en_mask));

   // R3
   cnt0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!glob_en_q || !en_mask[0]) && !wr_en_i) |=> $stable(cnt0));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_addr_i == ADDR_W'(ADR_OVF))
      |=> ((ovf_mask & $past(ovf_mask)) == $past(ovf_mask)));

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ovf_mask != '0));

   // R11
   cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_open && !wr_en_i) |=> $stable(cyc_val));
endmodule

bind perf_mon perf_mon_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .irq_o     (irq_o),
   .glob_en_q (glob_en_q),
   .en_mask   (en_mask),
   .ovf_mask  (ovf_mask),
   .cyc_val   (cyc_val),
   .cyc_open  (cyc_open),
   .cnt0      (cnt_val[0]));

// File: tb/perf_mon_tb_top.sv
module perf_mon_tb_top;
   localparam int AW = 5;
   localparam int NC = 4;
   localparam int CB = 10 + NC;   // first count address
   localparam int SB = 10;        // first selector address

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic [31:0]   events = '0;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   perf_mon dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .events_i(events), .irq_o(irq));

   typedef struct packed {
      logic [9:0]  sel;
      logic [31:0] pat;
      logic [7:0]  n;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{10'd0,    32'hFFFF_FFFF, 8'd6, 32'd0},
      '{10'd1,    32'h0000_0000, 8'd7, 32'd7},
      '{10'd2,    32'h0000_0001, 8'd5, 32'd5},
      '{10'd5,    32'h0000_0004, 8'd4, 32'd0},
      '{10'd5,    32'h0000_0008, 8'd4, 32'd4},
      '{10'd33,   32'h8000_0000, 8'd3, 32'd3},
      '{10'd34,   32'hFFFF_FFFF, 8'd3, 32'd0},
      '{10'd1023, 32'hFFFF_FFFF, 8'd2, 32'd0}
   };

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic rd_now(input int a, input logic [31:0] exp, input string tag);
      rd_addr = AW'(a);
      #1;
      cmp(rd_data, exp, tag);
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_now(a, exp, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < NC; i++) rd(CB + i, 32'd0, "R1 count");
      rd(0, 32'd0, "R1 ctrl");
      rd(1, 32'd0, "R1 enable mask");
      rd(3, 32'd0, "R1 overflow");
      rd(4, 32'd0, "R1 irq mask");
      rd(7, 32'h1, "R1 cyc cfg");
      rd(8, 32'd0, "R1 cyc lo");
      rd(9, 32'd0, "R1 cyc hi");
      cmp({31'd0, irq}, 32'd0, "R1 irq");

      // R3 selector table, counter 0, window of n enabled edges
      foreach (VECS[v]) begin
         wr(0, 32'h2);
         wr(SB, 32'(VECS[v].sel));
         wr(1, 32'h1);
         @(negedge clk);
         events = VECS[v].pat;
         wr_en = 1'b1; wr_addr = AW'(0); wr_data = 32'h1;
         @(negedge clk);
         wr_en = 1'b0;
         repeat (int'(VECS[v].n) - 1) @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(0); wr_data = 32'h0;
         @(negedge clk);
         wr_en = 1'b0;
         events = '0;
         rd(CB, VECS[v].exp, "R3 selector vector");
      end
      wr(2, 32'hFFFF_FFFF);

      // R2 enable mask set/clear
      wr(1, 32'h8000_0005);
      rd(1, 32'h8000_0005, "R2 en set");
      wr(2, 32'h0000_0001);
      rd(1, 32'h8000_0004, "R2 en clr");
      rd(2, 32'h8000_0004, "R2 en read alias");
      wr(2, 32'hFFFF_FFFF);

      // R3 disabled counter does not count
      wr(SB + 1, 32'd1);
      wr(0, 32'h3);
      repeat (5) @(negedge clk);
      rd(CB + 1, 32'd0, "R3 disabled counter");
      wr(0, 32'h2);

      // R4 load wins over counting in the same clock
      wr(SB, 32'd1);
      wr(1, 32'h1);
      wr(0, 32'h1);
      wr(CB, 32'd100);
      rd_now(CB, 32'd100, "R4 load priority");
      rd(CB, 32'd101, "R4 counting after load");
      // R5 event counter clear
      wr(0, 32'h2);
      rd(CB, 32'd0, "R5 event clear");
      wr(2, 32'hFFFF_FFFF);

      // R6 software increment, enables off
      wr(CB + 2, 32'd5);
      wr(6, 32'h4);
      rd(CB + 2, 32'd6, "R6 sw increment");
      rd(CB + 3, 32'd0, "R6 unselected untouched");

      // R9 / R10 overflow and interrupt
      wr(CB, 32'hFFFF_FFFF);
      wr(6, 32'h1);
      rd(CB, 32'd0, "R9 wrap value");
      rd(3, 32'h1, "R9 overflow set");
      cmp({31'd0, irq}, 32'd0, "R10 irq masked");
      wr(4, 32'h1);
      rd(4, 32'h1, "R10 irq mask read");
      cmp({31'd0, irq}, 32'd1, "R10 irq raised");
      wr(3, 32'h0);
      rd(3, 32'h1, "R9 zero write keeps status");
      wr(3, 32'h1);
      rd(3, 32'h0, "R9 w1c");
      cmp({31'd0, irq}, 32'd0, "R10 irq drops");
      wr(5, 32'h1);
      rd(5, 32'h0, "R10 irq mask clear");

      // R7 cycle counter carry and wrap via software increment
      wr(8, 32'hFFFF_FFFF);
      wr(9, 32'h0);
      wr(6, 32'h8000_0000);
      rd(8, 32'd0, "R7 low wraps");
      rd(9, 32'd1, "R7 carry same edge");
      wr(0, 32'h4);
      rd(9, 32'd0, "R5 cycle clear");
      wr(8, 32'hFFFF_FFFF);
      wr(9, 32'hFFFF_FFFF);
      wr(6, 32'h8000_0000);
      rd(9, 32'd0, "R7 full wrap hi");
      rd(3, 32'h8000_0000, "R9 cycle overflow");
      wr(3, 32'h8000_0000);

      // R8 / R11 start-stop gating: start on events[3], stop on events[4]
      wr(7, (32'd6 << 16) | 32'd5);
      rd(7, (32'd6 << 16) | 32'd5, "R8 cfg readback");
      @(negedge clk); events = 32'h10;
      @(negedge clk); events = 32'h0;
      wr(0, 32'h5);
      wr(1, 32'h8000_0000);
      repeat (3) @(negedge clk);
      rd(8, 32'd0, "R11 unarmed holds");
      @(negedge clk); events = 32'h08;
      @(negedge clk); events = 32'h0;
      repeat (4) @(negedge clk);
      events = 32'h10;
      @(negedge clk); events = 32'h0;
      rd(8, 32'd5, "R8 start to stop count");
      rd(8, 32'd5, "R8 stopped holds");
      rd(9, 32'd0, "R8 hi stays");
      wr(0, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule